// File: doc/BRIEF.md
# Frame-Locked Line-Buffer Video Converter

This block moves pixels made by a core on its own pixel clock into a standard output raster that runs on an unrelated video clock. Each accepted input pixel is written into a small dual-clock store that holds a few lines. The output side reads the store when the raster scans across a placed window. The output raster does not drift against the input frame. Each time the input reaches a chosen line, the output counters are forced back to their origin.

The picture is not scaled. In interlaced mode each stored line is shown once. In progressive mode each stored line is shown twice. An optional scanline effect darkens the repeated copy to one of three levels. The window position, the raster timing, the store size, the lock line and a read-line correction are all parameters.

Input pixels use a valid/ready handshake. A beat is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high for the rest of the time, so a running input is never back-pressured. The sync, blank and colour pins on the output side are plain registered signals.

Top module: `vlb_converter`

## Requirements
- R1: `in_ready` is 0 while `rst_in_n` is low and 1 from the cycle after reset is released. A beat is taken when `in_valid` and `in_ready` are both 1.
- R2: The store holds 2^H_ADDR_W pixels for each of 2^V_ADDR_W lines. The input line index becomes 0 on a beat with `in_sof`=1. It increases by one on each beat with `in_sol`=1 and `in_sof`=0. A line goes into slot (line index mod 2^V_ADDR_W). The column is 0 on a beat with `in_sof` or `in_sol` set and increases by one per taken beat. Pixels at column 2^H_ADDR_W or above are dropped and never wrap onto low columns.
- R3: When a line start makes the input line index equal to MATCH_LINE, the output raster restarts at its origin. `vid_vsync` then rises within 10 video cycles. Line starts at other indices do not restart it.
- R4: When no resync occurs, the raster has a period of H_TOTAL×V_TOTAL video cycles. `vid_hsync` is 1 during the first H_SYNC cycles of every line, which gives V_TOTAL hsync pulses per frame. `vid_vsync` is 1 during the first V_SYNC lines. Both pulses are active-high, and `vid_vsync` rises together with `vid_hsync`.
- R5: `vid_blank` is 0 only inside the window. With h and v the output counters, ax = h−H_OFFSET lies in [0, ACT_W), ay = v−V_OFFSET lies in [0, ACT_H), and ax < 2^H_ADDR_W. Window columns at or above 2^H_ADDR_W are blank.
- R6: Inside the window, the pixel at column ax comes from slot (src + L_OFFSET) mod 2^V_ADDR_W. Here src = ay when `vid_progressive`=0, and src = ay/2 (each line twice) when it is 1.
- R7: In progressive mode, rows with odd ay are dimmed per channel according to `vid_scan_lvl`. The value 01 gives c/4, 10 gives c/2 and 11 gives c/2+c/4, each using truncating shifts. The value 00 leaves rows unchanged, and interlaced mode never dims.
- R8: While `vid_blank` is 1, all colour outputs are 0.
- R9: While `rst_vid_n` is low, `vid_blank` is 1 and the colour and sync outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Core pixel clock |
| rst_in_n | input | 1 | Active-low synchronous reset, input domain |
| in_valid | input | 1 | Input pixel beat valid |
| in_ready | output | 1 | Beat accepted when high |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_r | input | CW | Red component |
| in_g | input | CW | Green component |
| in_b | input | CW | Blue component |
| clk_vid | input | 1 | Output video clock |
| rst_vid_n | input | 1 | Active-low synchronous reset, video domain |
| vid_progressive | input | 1 | 1: line-doubled progressive, 0: interlaced single lines |
| vid_scan_lvl | input | 2 | Scanline dimming level, 00 = off |
| vid_hsync | output | 1 | Horizontal sync, active high |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_blank | output | 1 | High outside the placed window |
| vid_r | output | CW | Red out |
| vid_g | output | CW | Green out |
| vid_b | output | CW | Blue out |

## Verification
Suppose the write column or line counter drifts. The bench then sees wrong or shifted colours at the first window pixel that reads the affected slot, which is at most one output frame later. A stuck or mistimed resync shows up at the ports in two ways: a vsync rise that is missing or arrives late after the lock line, or a frame period that differs from H_TOTAL×V_TOTAL. Either one is visible within a single frame. Errors in the window or dimming state appear in the same output line as blank pixels that carry colour, a wrong count of unblanked pixels, or wrongly shaded odd rows.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  // Scanline shading levels applied to the repeated row.
  typedef enum logic [1:0] {
    DIM_OFF     = 2'b00,
    DIM_QUARTER = 2'b01,
    DIM_HALF    = 2'b10,
    DIM_3Q      = 2'b11
  } dim_lvl_e;
endpackage

// File: rtl/vlb_write_side.sv
module vlb_write_side #(
  parameter int H_ADDR_W   = 9,
  parameter int V_ADDR_W   = 3,
  parameter int PIX_W      = 24,
  parameter int LINE_W     = 11,
  parameter int MATCH_LINE = 0,
  localparam int AW = H_ADDR_W + V_ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             sof,
  input  logic             sol,
  input  logic [PIX_W-1:0] pix,
  output logic             ready,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [PIX_W-1:0] wdata,
  output logic             match_tgl
);
  localparam logic [H_ADDR_W:0] X_ONE = (H_ADDR_W+1)'(1);
  localparam logic [LINE_W-1:0] L_ONE = LINE_W'(1);

  logic [H_ADDR_W:0] x_q, x_d;   // top bit set = past the stored width
  logic [LINE_W-1:0] line_q, line_d;
  logic              take, starts_line;

  assign take        = valid & ready;
  assign starts_line = sof | sol;

  always_comb begin
    line_d = line_q;
    x_d    = x_q;
    if (take) begin
      if (sof)      line_d = '0;
      else if (sol) line_d = line_q + L_ONE;
      if (starts_line)        x_d = '0;
      else if (!x_q[H_ADDR_W]) x_d = x_q + X_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      we        <= 1'b0;
      x_q       <= '0;
      line_q    <= '0;
      match_tgl <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      ready  <= 1'b1;
      x_q    <= x_d;
      line_q <= line_d;
      we     <= take & ~x_d[H_ADDR_W];
      waddr  <= {line_d[V_ADDR_W-1:0], x_d[H_ADDR_W-1:0]};
      wdata  <= pix;
      if (take && starts_line && (line_d == LINE_W'(MATCH_LINE)))
        match_tgl <= ~match_tgl;
    end
  end
endmodule

// File: rtl/vlb_buffer_ram.sv
module vlb_buffer_ram #(
  parameter int AW = 12,
  parameter int DW = 24,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vlb_sync_pulse.sv
module vlb_sync_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tgl_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 ^ s3;
endmodule

// File: rtl/vlb_raster.sv
module vlb_raster
  import vlb_pkg::*;
#(
  parameter int H_ADDR_W = 9,
  parameter int V_ADDR_W = 3,
  parameter int CW       = 8,
  parameter int H_TOTAL  = 858,
  parameter int V_TOTAL  = 525,
  parameter int H_SYNC   = 62,
  parameter int V_SYNC   = 6,
  parameter int H_OFFSET = 104,
  parameter int V_OFFSET = 18,
  parameter int ACT_W    = 512,
  parameter int ACT_H    = 480,
  parameter int L_OFFSET = 2,
  localparam int AW     = H_ADDR_W + V_ADDR_W,
  localparam int PIX_W  = 3 * CW,
  localparam int HC_W   = $clog2(H_TOTAL),
  localparam int VC_W   = $clog2(V_TOTAL),
  localparam int H_SPAN = 1 << H_ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             progressive,
  input  logic [1:0]       scan_lvl,
  output logic [AW-1:0]    raddr,
  input  logic [PIX_W-1:0] rdata,
  output logic             hsync,
  output logic             vsync,
  output logic             blank,
  output logic [PIX_W-1:0] rgb
);
  logic [HC_W-1:0] h_q;
  logic [VC_W-1:0] v_q;
  logic            h_last, v_last;
  logic [31:0]     hx, vy, ax, ay, src;
  logic            act0, dim0, hs0, vs0;
  logic [V_ADDR_W-1:0] rline;

  assign hx     = 32'(h_q);
  assign vy     = 32'(v_q);
  assign h_last = (hx == 32'(H_TOTAL - 1));
  assign v_last = (vy == 32'(V_TOTAL - 1));

  // Stage 0: raster counters, restarted by the frame lock pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (resync) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + VC_W'(1);
    end else begin
      h_q <= h_q + HC_W'(1);
    end
  end

  assign ax   = hx - 32'(H_OFFSET);
  assign ay   = vy - 32'(V_OFFSET);
  assign act0 = (hx >= 32'(H_OFFSET)) && (ax < 32'(ACT_W)) && (ax < 32'(H_SPAN))
             && (vy >= 32'(V_OFFSET)) && (ay < 32'(ACT_H));
  assign src  = progressive ? (ay >> 1) : ay;
  assign rline = V_ADDR_W'(src + 32'(L_OFFSET));
  assign raddr = {rline, ax[H_ADDR_W-1:0]};
  assign dim0  = progressive && ay[0] && (scan_lvl != 2'b00);
  assign hs0   = hx < 32'(H_SYNC);
  assign vs0   = vy < 32'(V_SYNC);

  // Stage 1: aligned with the registered buffer read.
  logic     act1, dim1, hs1, vs1;
  dim_lvl_e lvl1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act1 <= 1'b0;
      dim1 <= 1'b0;
      hs1  <= 1'b0;
      vs1  <= 1'b0;
      lvl1 <= DIM_OFF;
    end else begin
      act1 <= act0;
      dim1 <= dim0;
      hs1  <= hs0;
      vs1  <= vs0;
      lvl1 <= dim_lvl_e'(scan_lvl);
    end
  end

  // Per-channel shift-and-add shading.
  logic [PIX_W-1:0] shaded;
  for (genvar c = 0; c < 3; c++) begin : g_chan
    logic [CW-1:0] cin, cout;
    assign cin = rdata[c*CW +: CW];
    always_comb begin
      case (lvl1)
        DIM_QUARTER: cout = cin >> 2;
        DIM_HALF:    cout = cin >> 1;
        DIM_3Q:      cout = (cin >> 1) + (cin >> 2);
        default:     cout = cin;
      endcase
    end
    assign shaded[c*CW +: CW] = cout;
  end

  // Stage 2: registered outputs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      blank <= 1'b1;
      rgb   <= '0;
    end else begin
      hsync <= hs1;
      vsync <= vs1;
      blank <= ~act1;
      rgb   <= act1 ? (dim1 ? shaded : rdata) : '0;
    end
  end
endmodule

// File: rtl/vlb_converter.sv
module vlb_converter #(
  parameter int H_ADDR_W   = 9,
  parameter int V_ADDR_W   = 3,
  parameter int CW         = 8,
  parameter int LINE_W     = 11,
  parameter int MATCH_LINE = 0,
  parameter int H_TOTAL    = 858,
  parameter int V_TOTAL    = 525,
  parameter int H_SYNC     = 62,
  parameter int V_SYNC     = 6,
  parameter int H_OFFSET   = 104,
  parameter int V_OFFSET   = 18,
  parameter int ACT_W      = 512,
  parameter int ACT_H      = 480,
  parameter int L_OFFSET   = 2
) (
  input  logic          clk_in,
  input  logic          rst_in_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic          clk_vid,
  input  logic          rst_vid_n,
  input  logic          vid_progressive,
  input  logic [1:0]    vid_scan_lvl,
  output logic          vid_hsync,
  output logic          vid_vsync,
  output logic          vid_blank,
  output logic [CW-1:0] vid_r,
  output logic [CW-1:0] vid_g,
  output logic [CW-1:0] vid_b
);
  localparam int AW    = H_ADDR_W + V_ADDR_W;
  localparam int PIX_W = 3 * CW;

  logic             wr_en;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [PIX_W-1:0] wr_data, rd_data, vid_rgb;
  logic             match_tgl, match_pulse;

  vlb_write_side #(
    .H_ADDR_W(H_ADDR_W), .V_ADDR_W(V_ADDR_W), .PIX_W(PIX_W),
    .LINE_W(LINE_W), .MATCH_LINE(MATCH_LINE)
  ) u_wr (
    .clk(clk_in), .rst_n(rst_in_n), .valid(in_valid), .sof(in_sof), .sol(in_sol),
    .pix({in_r, in_g, in_b}), .ready(in_ready), .we(wr_en), .waddr(wr_addr),
    .wdata(wr_data), .match_tgl(match_tgl)
  );

  vlb_buffer_ram #(.AW(AW), .DW(PIX_W)) u_ram (
    .wclk(clk_in), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(clk_vid), .raddr(rd_addr), .rdata(rd_data)
  );

  vlb_sync_pulse u_lock (
    .clk(clk_vid), .rst_n(rst_vid_n), .tgl_in(match_tgl), .pulse(match_pulse)
  );

  vlb_raster #(
    .H_ADDR_W(H_ADDR_W), .V_ADDR_W(V_ADDR_W), .CW(CW),
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_SYNC(H_SYNC), .V_SYNC(V_SYNC),
    .H_OFFSET(H_OFFSET), .V_OFFSET(V_OFFSET), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .L_OFFSET(L_OFFSET)
  ) u_rast (
    .clk(clk_vid), .rst_n(rst_vid_n), .resync(match_pulse),
    .progressive(vid_progressive), .scan_lvl(vid_scan_lvl),
    .raddr(rd_addr), .rdata(rd_data),
    .hsync(vid_hsync), .vsync(vid_vsync), .blank(vid_blank), .rgb(vid_rgb)
  );

  assign {vid_r, vid_g, vid_b} = vid_rgb;
endmodule

// File: rtl/vlb_checker.sv
module vlb_checker #(
  parameter int CW = 8
) (
  input logic          clk_in,
  input logic          rst_in_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          wr_en,
  input logic          clk_vid,
  input logic          rst_vid_n,
  input logic          match_pulse,
  input logic          vid_hsync,
  input logic          vid_vsync,
  input logic          vid_blank,
  input logic [CW-1:0] vid_r,
  input logic [CW-1:0] vid_g,
  input logic [CW-1:0] vid_b
);
  p_ready_after_reset_r1: assert property (@(posedge clk_in) disable iff (!rst_in_n)
    $past(rst_in_n) |-> in_ready);

  p_write_follows_accept_r2: assert property (@(posedge clk_in) disable iff (!rst_in_n)
    wr_en |-> $past(in_valid && in_ready));

  p_resync_origin_r3: assert property (@(posedge clk_vid) disable iff (!rst_vid_n)
    match_pulse |-> ##3 (vid_vsync && vid_hsync));

  p_vsync_with_hsync_r4: assert property (@(posedge clk_vid) disable iff (!rst_vid_n)
    $rose(vid_vsync) |-> vid_hsync);

  p_sync_in_blank_r5: assert property (@(posedge clk_vid) disable iff (!rst_vid_n)
    vid_hsync |-> vid_blank);

  p_black_when_blank_r8: assert property (@(posedge clk_vid) disable iff (!rst_vid_n)
    vid_blank |-> ({vid_r, vid_g, vid_b} == '0));
endmodule

bind vlb_converter vlb_checker #(.CW(CW)) u_chk (
  .clk_in(clk_in), .rst_in_n(rst_in_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_en(wr_en), .clk_vid(clk_vid), .rst_vid_n(rst_vid_n), .match_pulse(match_pulse),
  .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_blank(vid_blank),
  .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
);

// File: tb/vlb_converter_test.sv
module vlb_converter_test;
  localparam int VID_PERIOD = 10;
  localparam int IN_HALF    = 3;
  localparam int HW = 4, VW = 3, CW = 8;
  localparam int HT = 32, VT = 16, HS = 3, VS = 2;
  localparam int HO = 6, VO = 3, AWID = 18, AHGT = 8, LOFF = 2, MLINE = 2;
  localparam int SPAN = 1 << HW;
  localparam int SLOTS = 1 << VW;
  localparam int LINE_PIX = 20;

  logic clk_in = 1'b0, clk_vid = 1'b0;
  logic rst_in_n = 1'b0, rst_vid_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [CW-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_ready;
  logic vid_progressive = 1'b0;
  logic [1:0] vid_scan_lvl = 2'b00;
  logic vid_hsync, vid_vsync, vid_blank;
  logic [CW-1:0] vid_r, vid_g, vid_b;

  always #(IN_HALF) clk_in = ~clk_in;
  always #(VID_PERIOD/2) clk_vid = ~clk_vid;

  vlb_converter #(
    .H_ADDR_W(HW), .V_ADDR_W(VW), .CW(CW), .LINE_W(8), .MATCH_LINE(MLINE),
    .H_TOTAL(HT), .V_TOTAL(VT), .H_SYNC(HS), .V_SYNC(VS),
    .H_OFFSET(HO), .V_OFFSET(VO), .ACT_W(AWID), .ACT_H(AHGT), .L_OFFSET(LOFF)
  ) uut (
    .clk_in(clk_in), .rst_in_n(rst_in_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_sol(in_sol), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .clk_vid(clk_vid), .rst_vid_n(rst_vid_n), .vid_progressive(vid_progressive),
    .vid_scan_lvl(vid_scan_lvl), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_blank(vid_blank), .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b)
  );

  int checks = 0, errors = 0;

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] pix(int l, int x);
    return {8'(l * 16 + x), 8'(x * 5 + l * 3 + 1), 8'(250 - l * 9 - x * 2)};
  endfunction

  function automatic logic [7:0] shade(logic [7:0] c, logic [1:0] lvl);
    case (lvl)
      2'b01:   return c >> 2;
      2'b10:   return c >> 1;
      2'b11:   return (c >> 1) + (c >> 2);
      default: return c;
    endcase
  endfunction

  // ---- input driver ----
  task automatic send_pix(logic sof, logic sol, logic [23:0] p);
    @(negedge clk_in);
    in_valid = 1'b1; in_sof = sof; in_sol = sol;
    {in_r, in_g, in_b} = p;
  endtask

  task automatic idle_in();
    @(negedge clk_in);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  task automatic send_line(int l, bit first);
    for (int x = 0; x < LINE_PIX; x++) send_pix(first && x == 0, x == 0, pix(l, x));
  endtask

  // ---- sync observers ----
  int  vs_rises = 0, hs_rises = 0;
  time last_rise = 0;
  logic vs_prev = 1'b0, hs_prev = 1'b0;
  always @(negedge clk_vid) begin
    if (vid_vsync && !vs_prev) begin
      vs_rises++;
      last_rise = $time;
    end
    if (vid_hsync && !hs_prev) hs_rises++;
    vs_prev = vid_vsync;
    hs_prev = vid_hsync;
  end

  task automatic wait_vsync_rise();
    int n = vs_rises;
    while (vs_rises == n) @(posedge clk_vid);
    @(negedge clk_vid);
  endtask

  // ---- scoreboard ----
  logic [23:0] exp_q[$];
  string       tag_q[$];
  bit          mon_en = 1'b0;
  int          shown = 0;

  always @(negedge clk_vid) begin
    if (mon_en) begin
      if (!vid_blank) begin
        shown++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: unexpected visible pixel %h expected none", {vid_r, vid_g, vid_b});
        end else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if ({vid_r, vid_g, vid_b} !== e) begin
            errors++;
            $display("FAIL %s: pixel got %h expected %h", t, {vid_r, vid_g, vid_b}, e);
          end
        end
      end else if ({vid_r, vid_g, vid_b} !== 24'h0) begin
        checks++; errors++;
        $display("FAIL R8: blanked colour got %h expected 000000", {vid_r, vid_g, vid_b});
      end
    end
  end

  task automatic run_frame(bit prog, logic [1:0] lvl);
    wait_vsync_rise();
    vid_progressive = prog;
    vid_scan_lvl    = lvl;
    for (int ay = 0; ay < AHGT; ay++) begin
      for (int ax = 0; ax < SPAN; ax++) begin
        int src = prog ? ay / 2 : ay;
        int slot = (src + LOFF) % SLOTS;
        logic [23:0] v = pix(slot, ax);
        bit dim = prog && (ay % 2 == 1) && (lvl != 2'b00);
        if (dim) v = {shade(v[23:16], lvl), shade(v[15:8], lvl), shade(v[7:0], lvl)};
        exp_q.push_back(v);
        tag_q.push_back(dim ? "R7" : (ax < 4 ? "R2" : "R6"));
      end
    end
    shown  = 0;
    mon_en = 1'b1;
    wait_vsync_rise();
    mon_en = 1'b0;
    chk("R5 visible pixel count", shown, AHGT * SPAN);
    chk("R6 leftover expected items", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(VID_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R9 / R1: reset state
    #50;
    chk("R9 blank in reset", vid_blank, 1);
    chk("R9 colour in reset", {vid_r, vid_g, vid_b}, 0);
    chk("R9 hsync in reset", vid_hsync, 0);
    chk("R9 vsync in reset", vid_vsync, 0);
    chk("R1 ready in reset", in_ready, 0);
    #50;
    rst_vid_n = 1'b1;
    rst_in_n  = 1'b1;
    repeat (3) @(negedge clk_in);
    chk("R1 ready after reset", in_ready, 1);

    // Fill every slot; lines are longer than the stored width (R2 drop)
    for (int l = 0; l < SLOTS; l++) send_line(l, l == 0);
    idle_in();

    // R4: free-running period, hsync count and alignment
    begin
      time t1;
      int  h0;
      wait_vsync_rise();
      t1 = last_rise;
      h0 = hs_rises;
      chk("R4 hsync high at vsync rise", vid_hsync, 1);
      wait_vsync_rise();
      chk("R4 frame period", (last_rise - t1) / VID_PERIOD, HT * VT);
      chk("R4 hsync pulses per frame", hs_rises - h0, VT);
    end

    // Scoreboarded frames across modes and levels
    run_frame(1'b0, 2'b11);   // interlaced: no dimming even with level set (R7)
    run_frame(1'b1, 2'b00);   // doubled, no shading (R6/R7)
    run_frame(1'b1, 2'b01);
    run_frame(1'b1, 2'b10);
    run_frame(1'b1, 2'b11);

    // R3: only the lock line restarts the raster
    begin
      int  r0;
      time t0;
      wait_vsync_rise();
      repeat (100) @(negedge clk_vid);
      r0 = vs_rises;
      send_line(0, 1'b1);
      send_line(1, 1'b0);
      chk("R3 no restart on other lines", vs_rises, r0);
      send_pix(1'b0, 1'b1, pix(MLINE, 0));
      t0 = $time;
      for (int x = 1; x < LINE_PIX; x++) send_pix(1'b0, 1'b0, pix(MLINE, x));
      idle_in();
      repeat (4) @(negedge clk_vid);
      chk("R3 restart on lock line", vs_rises, r0 + 1);
      checks++;
      if ((last_rise - t0) < 2 * VID_PERIOD || (last_rise - t0) > 10 * VID_PERIOD) begin
        errors++;
        $display("FAIL R3: lock latency got %0d expected 20..100", last_rise - t0);
      end
      for (int l = MLINE + 1; l < SLOTS; l++) send_line(l, 1'b0);
      idle_in();
    end

    // Buffer unchanged after relock: one more frame
    run_frame(1'b0, 2'b00);
    finish_run();
  end
endmodule